// File: doc/BRIEF.md
# Two-Phase Lag Autocorrelator

This block is the correlator core of a spectrometer. It takes one digitized signal stream and builds its autocorrelation over a fixed set of lags, from lag 0 up to lag NUM_LAGS-1. Each lag has its own cell that delays the signal, multiplies the delayed value by the current value, and adds the product into a running sum. Because both multiplier operands come from the same stream, the result is an autocorrelation and not a cross-correlation. All cells run on one clock.

The stream arrives two samples per clock. In each transfer the even-phase sample comes earlier in time than the odd-phase sample. The datapath is therefore built twice, once for each phase, so the internal clock runs at half the sample rate. Every cycle, each lag cell adds one product from each phase. For each lag, the cell takes the delayed operand from the same-phase delay line or from the opposite-phase delay line, depending on the parity of the lag. This keeps products that cross the phase boundary correct.

A start pulse does three things: it clears the cells, it clears the delay lines, and it captures the integration length. Once the programmed number of valid pairs has been summed, the block copies the sums to its outputs and raises a one-cycle done strobe. The reference samples reach the cells through a register stage, and the products pass through a second register stage. This keeps the fan-out to the last cell off the critical path.

Top module: `lagCorrelator`

## Requirements
- R1: Number the accepted pairs m = 0..L-1 after a start, with x[2m] = sampleEven and x[2m+1] = sampleOdd. The signed value at lagOut[k*ACC_W +: ACC_W] after done is the sum over n = k..2L-1 of x[n]*x[n-k]. Samples before the start count as zero. ACC_W = 2*SAMPLE_W + CNT_W + 1.
- R2: Odd lags pair each even-phase sample with the odd-phase sample of the previous pair. Each odd-phase sample is paired with an even-phase sample, so cross-phase products are neither lost nor doubled.
- R3: A cycle with clearIn high has several effects. It zeroes all sums and delay lines. It cancels any integration in flight, including a pending done. It captures intLen as L. The done strobe is low in the cycle after clearIn.
- R4: Cycles with validIn low leave the delay lines and sums unchanged. Idle gaps between pairs do not alter the result.
- R5: doneOut is high for exactly one cycle. It rises on the third rising edge after the edge that accepts the L-th pair.
- R6: lagOut changes only on the edge that raises doneOut. It holds its value through a following start and integration.
- R7: Pairs offered before any start, or after the L-th pair of an integration, are ignored. They produce no done and no change of lagOut.
- R8: A start with intLen equal to zero accepts no pairs and never raises doneOut.
- R9: Full-scale inputs over the largest integration length (2^CNT_W - 1 pairs) produce exact sums without overflow. Two cases cover this: all samples at -128, and +127 alternating with -128.
- R10: During and right after reset, lagOut is zero and doneOut is low.
- R11: A sample pair presented with validIn high in the same cycle as clearIn is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at half the sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| clearIn | input | 1 | Start pulse: clear and capture the length |
| intLen | input | CNT_W | Number of sample pairs to integrate |
| validIn | input | 1 | The sample pair is valid this cycle |
| sampleEven | input | SAMPLE_W | Earlier sample of the pair, signed |
| sampleOdd | input | SAMPLE_W | Later sample of the pair, signed |
| lagOut | output | NUM_LAGS*ACC_W | Frozen lag sums, lag k at bits k*ACC_W and up, signed |
| doneOut | output | 1 | One-cycle strobe when new results are presented |

## Verification
Some properties are checked on every cycle:
- the done strobe never lasts more than one cycle;
- the outputs move only together with done;
- a start pulse suppresses done in the following cycle;
- each frozen result set is self-consistent: lag 0 is non-negative, and no lag exceeds lag 0 in magnitude, which follows from the Cauchy-Schwarz inequality.

The exact lag values, the handling of cross-phase products at odd lags, the three-cycle latency, the effect of idle gaps, the discarded pairs and the full-scale sums can only be shown by the bench's scenarios. Those scenarios compare every lag against sums that the bench computes itself.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clearAll;  // zero delay lines, product stage and sums
    logic shiftEn;   // accept the incoming pair into the delay lines
    logic prodEn;    // register the products of the newest pair
    logic accEn;     // add the registered products into the sums
    logic freeze;    // copy the sums to the outputs
  } ctlStrobes_t;

endpackage

// File: rtl/lagCtl.sv
module lagCtl
  import lagcorr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearIn,
  input  logic             validIn,
  input  logic [CNT_W-1:0] intLen,
  output ctlStrobes_t      ctl,
  output logic             doneOut
);

  logic             running;
  logic [CNT_W-1:0] lenReg;
  logic [CNT_W-1:0] cnt;
  logic             vldA, vldB;
  logic             lastA, lastB, lastC;
  logic             doneR;
  logic             accept;
  logic             isLast;

  assign accept = running & validIn & ~clearIn;
  assign isLast = ({1'b0, cnt} + (CNT_W+1)'(1)) == {1'b0, lenReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      lenReg  <= '0;
      cnt     <= '0;
      vldA    <= 1'b0;
      vldB    <= 1'b0;
      lastA   <= 1'b0;
      lastB   <= 1'b0;
      lastC   <= 1'b0;
      doneR   <= 1'b0;
    end else if (clearIn) begin
      running <= (intLen != '0);
      lenReg  <= intLen;
      cnt     <= '0;
      vldA    <= 1'b0;
      vldB    <= 1'b0;
      lastA   <= 1'b0;
      lastB   <= 1'b0;
      lastC   <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      vldA  <= accept;
      lastA <= accept & isLast;
      if (accept) begin
        cnt <= cnt + CNT_W'(1);
        if (isLast) running <= 1'b0;
      end
      vldB  <= vldA;
      lastB <= lastA;
      lastC <= lastB;
      doneR <= lastC;
    end
  end

  always_comb begin
    ctl.clearAll = clearIn;
    ctl.shiftEn  = accept;
    ctl.prodEn   = vldA;
    ctl.accEn    = vldB;
    ctl.freeze   = lastC & ~clearIn;
  end

  assign doneOut = doneR;

endmodule

// File: rtl/lagPath.sv
module lagPath
  import lagcorr_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int NUM_LAGS = 8,
  parameter int ACC_W    = 25
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                ctl,
  input  logic signed [SAMPLE_W-1:0] sampleEven,
  input  logic signed [SAMPLE_W-1:0] sampleOdd,
  output logic [NUM_LAGS*ACC_W-1:0]  lagOut
);

  localparam int LINE_D = NUM_LAGS / 2 + 1;
  localparam int MUL_W  = 2 * SAMPLE_W;
  localparam int PAIR_W = MUL_W + 1;

  // Index 0 holds the newest accepted pair and also serves as the
  // registered broadcast of the reference samples to every lag cell.
  logic signed [SAMPLE_W-1:0] lineE [LINE_D];
  logic signed [SAMPLE_W-1:0] lineO [LINE_D];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      for (int j = 0; j < LINE_D; j++) begin
        lineE[j] <= '0;
        lineO[j] <= '0;
      end
    end else if (ctl.shiftEn) begin
      lineE[0] <= sampleEven;
      lineO[0] <= sampleOdd;
      for (int j = 1; j < LINE_D; j++) begin
        lineE[j] <= lineE[j-1];
        lineO[j] <= lineO[j-1];
      end
    end
  end

  for (genvar k = 0; k < NUM_LAGS; k++) begin : g_lag
    logic signed [SAMPLE_W-1:0] evenOp, oddOp;
    logic signed [MUL_W-1:0]    prodE, prodO;
    logic signed [PAIR_W-1:0]   pairSum, pairReg;
    logic signed [ACC_W-1:0]    acc, lagReg;

    if (k % 2 == 1) begin : g_cross
      // odd lag: each phase reaches into the other phase's line
      assign evenOp = lineO[(k+1)/2];
      assign oddOp  = lineE[(k-1)/2];
    end else begin : g_same
      assign evenOp = lineE[k/2];
      assign oddOp  = lineO[k/2];
    end

    assign prodE   = MUL_W'(lineE[0]) * MUL_W'(evenOp);
    assign prodO   = MUL_W'(lineO[0]) * MUL_W'(oddOp);
    assign pairSum = PAIR_W'(prodE) + PAIR_W'(prodO);

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clearAll) begin
        pairReg <= '0;
        acc     <= '0;
      end else begin
        if (ctl.prodEn) pairReg <= pairSum;
        if (ctl.accEn)  acc     <= acc + ACC_W'(pairReg);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)           lagReg <= '0;
      else if (ctl.freeze) lagReg <= acc;
    end

    assign lagOut[k*ACC_W +: ACC_W] = lagReg;
  end

endmodule

// File: rtl/lagCorrelator.sv
module lagCorrelator
  import lagcorr_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int NUM_LAGS = 8,
  parameter int CNT_W    = 8,
  localparam int ACC_W   = 2 * SAMPLE_W + CNT_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearIn,
  input  logic [CNT_W-1:0]           intLen,
  input  logic                       validIn,
  input  logic signed [SAMPLE_W-1:0] sampleEven,
  input  logic signed [SAMPLE_W-1:0] sampleOdd,
  output logic [NUM_LAGS*ACC_W-1:0]  lagOut,
  output logic                       doneOut
);

  ctlStrobes_t ctl;

  lagCtl #(.CNT_W(CNT_W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .clearIn (clearIn),
    .validIn (validIn),
    .intLen  (intLen),
    .ctl     (ctl),
    .doneOut (doneOut)
  );

  lagPath #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_LAGS (NUM_LAGS),
    .ACC_W    (ACC_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleEven (sampleEven),
    .sampleOdd  (sampleOdd),
    .lagOut     (lagOut)
  );

endmodule

// File: rtl/lagCorrelator_chk.sv
module lagCorrelator_chk #(
  parameter int NUM_LAGS = 8,
  parameter int ACC_W    = 25
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      clearIn,
  input logic [NUM_LAGS*ACC_W-1:0] lagOut,
  input logic                      doneOut
);

  logic signed [ACC_W:0] zeroLag;
  logic signed [ACC_W:0] cur;
  logic signed [ACC_W:0] mag;
  logic                  boundOk;

  always_comb begin
    zeroLag = (ACC_W+1)'($signed(lagOut[ACC_W-1:0]));
    boundOk = 1'b1;
    cur     = '0;
    mag     = '0;
    for (int k = 1; k < NUM_LAGS; k++) begin
      cur = (ACC_W+1)'($signed(lagOut[k*ACC_W +: ACC_W]));
      mag = (cur < 0) ? -cur : cur;
      if (mag > zeroLag) boundOk = 1'b0;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(lagOut));

  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> !doneOut);

  // R1
  lag0_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !zeroLag[ACC_W]);

  // R1
  lag_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> boundOk);

endmodule

bind lagCorrelator lagCorrelator_chk #(
  .NUM_LAGS (NUM_LAGS),
  .ACC_W    (ACC_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .clearIn (clearIn),
  .lagOut  (lagOut),
  .doneOut (doneOut)
);

// File: tb/test_lagCorrelator.sv
module test_lagCorrelator;

  localparam int SW    = 8;
  localparam int NL    = 8;
  localparam int CW    = 8;
  localparam int ACC_W = 2 * SW + CW + 1;
  localparam int MAXN  = 2 * ((1 << CW) - 1);

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    clearIn;
  logic [CW-1:0]           intLen;
  logic                    validIn;
  logic signed [SW-1:0]    sampleEven;
  logic signed [SW-1:0]    sampleOdd;
  logic [NL*ACC_W-1:0]     lagOut;
  logic                    doneOut;

  int total = 0;
  int bad   = 0;
  int xs [MAXN];
  logic [NL*ACC_W-1:0] prevOut;

  always #10 clk = ~clk;

  lagCorrelator #(.SAMPLE_W(SW), .NUM_LAGS(NL), .CNT_W(CW)) i_lagCorrelator (
    .clk        (clk),
    .rstN       (rstN),
    .clearIn    (clearIn),
    .intLen     (intLen),
    .validIn    (validIn),
    .sampleEven (sampleEven),
    .sampleOdd  (sampleOdd),
    .lagOut     (lagOut),
    .doneOut    (doneOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lagVal(input int k);
    return longint'($signed(lagOut[k*ACC_W +: ACC_W]));
  endfunction

  task automatic checkAll(input int len, input string tag);
    for (int k = 0; k < NL; k++) begin
      longint e = 0;
      for (int n = k; n < 2 * len; n++) e += longint'(xs[n]) * longint'(xs[n-k]);
      // R1 for every lag; odd lags also exercise R2
      check(lagVal(k) == e, (k % 2 == 1) ? {tag, " R2 odd lag"} : {tag, " R1 lag"}, lagVal(k), e);
    end
  endtask

  function automatic int pick(input int mode, input bit isOdd, input int i);
    case (mode)
      1: return -128;
      2: return isOdd ? -128 : 127;
      3: return isOdd ? ($urandom_range(0, 255) - 128) : 0;
      4: return isOdd ? 0 : ($urandom_range(0, 255) - 128);
      5: return (i % 3 == 0) ? (isOdd ? 5 : -7) : 0;
      default: return $urandom_range(0, 255) - 128;
    endcase
  endfunction

  task automatic runCase(input int len, input int mode, input bit gaps, input bit dirtyClear, input string tag);
    prevOut = lagOut;
    @(negedge clk);
    clearIn    = 1'b1;
    intLen     = CW'(len);
    validIn    = dirtyClear;
    sampleEven = 8'sd99;
    sampleOdd  = -8'sd77;
    @(negedge clk);
    clearIn = 1'b0;
    validIn = 1'b0;
    // R3: no done in the cycle after a start
    check(doneOut == 1'b0, "R3 done after clear", doneOut, 0);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 2 == 1)) begin
        validIn    = 1'b0;
        sampleEven = 8'sd55;
        sampleOdd  = 8'sd66;
        repeat ($urandom_range(1, 3)) @(negedge clk);
      end
      xs[2*i]     = pick(mode, 1'b0, i);
      xs[2*i+1]   = pick(mode, 1'b1, i);
      sampleEven  = SW'(xs[2*i]);
      sampleOdd   = SW'(xs[2*i+1]);
      validIn     = 1'b1;
      @(negedge clk);
    end
    validIn    = 1'b0;
    sampleEven = 8'sd42;
    sampleOdd  = 8'sd42;
    check(doneOut == 1'b0, "R5 latency edge0", doneOut, 0);
    @(negedge clk);
    check(doneOut == 1'b0, "R5 latency edge1", doneOut, 0);
    @(negedge clk);
    check(doneOut == 1'b0, "R5 latency edge2", doneOut, 0);
    check(lagOut == prevOut, "R6 outputs held during run", lagVal(0), longint'($signed(prevOut[ACC_W-1:0])));
    @(negedge clk);
    check(doneOut == 1'b1, "R5 done on edge3", doneOut, 1);
    checkAll(len, tag);
    @(negedge clk);
    check(doneOut == 1'b0, "R5 done one cycle", doneOut, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; clearIn = 1'b0; intLen = '0; validIn = 1'b0;
    sampleEven = '0; sampleOdd = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(lagOut == '0, "R10 lagOut at reset", lagVal(0), 0);
    check(doneOut == 1'b0, "R10 done at reset", doneOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(lagOut == '0 && doneOut == 1'b0, "R10 after reset release", lagVal(0), 0);

    // R7: pairs before any start are ignored
    validIn = 1'b1; sampleEven = 8'sd100; sampleOdd = -8'sd3;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(doneOut == 1'b0, "R7 no done before start", doneOut, 0);
    end
    validIn = 1'b0;
    check(lagOut == '0, "R7 outputs untouched before start", lagVal(0), 0);

    // sweep of short lengths around the lag span, random data
    for (int len = 1; len <= 6; len++) runCase(len, 0, 1'b0, 1'b0, "sweep");
    runCase(3, 3, 1'b0, 1'b0, "odd-only");
    runCase(4, 4, 1'b0, 1'b0, "even-only");
    runCase(9, 5, 1'b0, 1'b0, "sparse");
    // R4: idle gaps between pairs
    runCase(20, 0, 1'b1, 1'b0, "R4 gaps");
    runCase(7, 5, 1'b1, 1'b0, "R4 sparse gaps");

    // R7: pairs after the last one are ignored
    prevOut = lagOut;
    validIn = 1'b1; sampleEven = 8'sd9; sampleOdd = 8'sd9;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(doneOut == 1'b0, "R7 no done after last pair", doneOut, 0);
    end
    validIn = 1'b0;
    check(lagOut == prevOut, "R7 outputs unchanged after last pair", lagVal(0), longint'($signed(prevOut[ACC_W-1:0])));

    // R8: zero length never completes
    @(negedge clk);
    clearIn = 1'b1; intLen = '0;
    @(negedge clk);
    clearIn = 1'b0; validIn = 1'b1; sampleEven = 8'sd1; sampleOdd = 8'sd2;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(doneOut == 1'b0, "R8 no done for zero length", doneOut, 0);
    end
    validIn = 1'b0;
    check(lagOut == prevOut, "R8 outputs unchanged", lagVal(0), longint'($signed(prevOut[ACC_W-1:0])));

    // R3 / R11: abort a run midway, restart with a pair on the clear cycle
    @(negedge clk);
    clearIn = 1'b1; intLen = CW'(10);
    @(negedge clk);
    clearIn = 1'b0; validIn = 1'b1; sampleEven = 8'sd120; sampleOdd = -8'sd120;
    repeat (4) @(negedge clk);
    validIn = 1'b0;
    runCase(5, 0, 1'b0, 1'b1, "R3 R11 restart");
    runCase(2, 0, 1'b0, 1'b1, "R11 short restart");

    // R9: full scale over the longest integration
    runCase((1 << CW) - 1, 1, 1'b0, 1'b0, "R9 all -128");
    runCase((1 << CW) - 1, 2, 1'b0, 1'b0, "R9 alternating");
    runCase(60, 0, 1'b1, 1'b0, "long random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule